// File: doc/BRIEF.md
# Oscillator Start-up Timer

This block holds off the core while an external crystal oscillator settles. It counts rising edges of the raw oscillator clock. It raises a ready flag once 1024 edges have been seen since the last restart. Any of five system events starts a new count: power-on, brown-out, wake from sleep, oscillator enable and power-up-timer expiry. While the count runs, the oscillator is reported as not stable, so a clock switch to it must wait.

The events arrive as one-cycle pulses in the system clock domain. A request/acknowledge handshake carries them into the oscillator domain, where the request holds the counter at zero. The terminal-count flag returns to the system domain through a two-flop synchronizer. The ready flag drops on the system cycle after an event, without waiting for any oscillator edge.

The timer only matters in the three crystal modes. In every other mode the oscillator is reported ready at once. The core stall output is raised only while the count runs and the system clock is taken from this oscillator. All pins are plain control and status levels or pulses; there is no streaming interface.

Top module: `osc_startup_timer`

## Requirements
- R1: `osc_mode` values 0, 1 and 2 are the crystal modes (low-power, standard, high-speed). For values 3 to 7, `osc_ready` is 1 and `core_stall` is 0 in the same cycle, whatever the events and the count.
- R2: After reset is released in a crystal mode, `osc_ready` stays 0 up to the 1023rd oscillator rising edge. It is 1 within two system cycles of the 1024th edge.
- R3: Each of the five event inputs starts a new count period on its own. Measured from the system edge that samples the event, `osc_ready` is 0 after the 1027th oscillator rising edge and 1 after the 1028th. The crossing takes two edges, the hold takes two more, and then 1024 edges are counted.
- R4: `osc_ready` is 0 in the first system cycle after an event is sampled in a crystal mode, even if no oscillator edge has occurred.
- R5: An event that arrives while a count is in progress discards the partial count. The full R3 timing then applies from the new event.
- R6: `core_stall` is 1 exactly when the mode is a crystal mode, `clk_src_pri` is 1 and `osc_ready` is 0.
- R7: The count saturates at 1024 and holds there. `osc_ready` stays 1 for any number of further oscillator edges until the next event.
- R8: Several events that arrive in the same system cycle cause one restart, with the same timing as a single event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| osc_clk | input | 1 | Raw oscillator clock being timed |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| osc_mode | input | 3 | Oscillator mode; 0..2 are crystal modes |
| ev_por | input | 1 | Power-on event pulse (system domain) |
| ev_bor | input | 1 | Brown-out event pulse (system domain) |
| ev_wake | input | 1 | Wake-from-sleep event pulse (system domain) |
| ev_osc_en | input | 1 | Oscillator-enable event pulse (system domain) |
| ev_pwrt | input | 1 | Power-up-timer expiry pulse (system domain) |
| clk_src_pri | input | 1 | System clock is sourced from this oscillator |
| osc_ready | output | 1 | Oscillator stable (system domain) |
| core_stall | output | 1 | Hold the program counter |

## Verification
The assertions assume the following about the inputs:
- Each event is a pulse of one system cycle.
- The oscillator period is longer than three system periods, so the handshake finishes within one oscillator period.
- The mode changes only between events.

The stimulus keeps to these rules. It drives events on falling system edges for exactly one cycle. It runs the oscillator at a 30 ns period against the 5 ns system clock. It changes the mode only while `osc_ready` is already known.

// File: rtl/ost_pkg.sv
package ost_pkg;

  typedef enum logic [2:0] {
    OM_XTAL_LOWPWR = 3'd0,
    OM_XTAL_STD    = 3'd1,
    OM_XTAL_FAST   = 3'd2,
    OM_EXT_CLK     = 3'd3,
    OM_EXT_CLK_IO  = 3'd4,
    OM_INT_RC      = 3'd5,
    OM_INT_RC_IO   = 3'd6,
    OM_SPARE       = 3'd7
  } osc_mode_e;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_REQ   = 2'd1,
    XF_DRAIN = 2'd2
  } xfer_state_e;

  function automatic logic mode_is_crystal(input logic [2:0] m);
    return (m == OM_XTAL_LOWPWR) || (m == OM_XTAL_STD) || (m == OM_XTAL_FAST);
  endfunction

endpackage

// File: rtl/ost_sync.sv
module ost_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ost_restart_xfer.sv
module ost_restart_xfer
  import ost_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic sys_clk,
  input  logic osc_clk,
  input  logic rst_n,
  input  logic ev_any,
  output logic hold_osc,
  output logic busy
);

  xfer_state_e state_q, state_d;
  logic        again_q, again_d;
  logic        req;
  logic        ack_s;

  assign req  = (state_q == XF_REQ);
  assign busy = (state_q != XF_IDLE);

  // request level into the oscillator domain; held there as counter clear
  ost_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (osc_clk),
    .rst_n (rst_n),
    .d     (req),
    .q     (hold_osc)
  );

  // acknowledge back into the system domain
  ost_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (sys_clk),
    .rst_n (rst_n),
    .d     (hold_osc),
    .q     (ack_s)
  );

  always_comb begin
    state_d = state_q;
    again_d = again_q;
    unique case (state_q)
      XF_IDLE: begin
        if (ev_any) state_d = XF_REQ;
      end
      XF_REQ: begin
        if (ack_s) state_d = XF_DRAIN;
      end
      XF_DRAIN: begin
        if (!ack_s) begin
          state_d = (again_q || ev_any) ? XF_REQ : XF_IDLE;
          again_d = 1'b0;
        end else if (ev_any) begin
          again_d = 1'b1;
        end
      end
      default: state_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      again_q <= 1'b0;
    end else begin
      state_q <= state_d;
      again_q <= again_d;
    end
  end

  // an event always leaves the handshake busy on the next cycle
  assert_event_sets_busy_R4: assert property (@(posedge sys_clk) disable iff (!rst_n)
    ev_any |=> busy);

  // the request stays up until the oscillator side has acknowledged it
  assert_req_held_R3: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (req && !ack_s) |=> req);

  // a pending re-request is only remembered while draining
  assert_again_only_draining_R5: assert property (@(posedge sys_clk) disable iff (!rst_n)
    again_q |-> (state_q == XF_DRAIN));

endmodule

// File: rtl/ost_cycle_counter.sv
module ost_cycle_counter #(
  parameter int LIMIT = 1024,
  localparam int CNT_W = $clog2(LIMIT) + 1
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic hold,
  output logic done
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (hold) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT_V) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == LIMIT_V);

  assert_no_overflow_R7: assert property (@(posedge osc_clk) disable iff (!rst_n)
    cnt_q <= LIMIT_V);

  assert_saturate_hold_R7: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (done && !hold) |=> done);

  assert_hold_clears_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0));

endmodule

// File: rtl/osc_startup_timer.sv
module osc_startup_timer
  import ost_pkg::*;
#(
  parameter int COUNT_LIMIT = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       sys_clk,
  input  logic       osc_clk,
  input  logic       rst_n,
  input  logic [2:0] osc_mode,
  input  logic       ev_por,
  input  logic       ev_bor,
  input  logic       ev_wake,
  input  logic       ev_osc_en,
  input  logic       ev_pwrt,
  input  logic       clk_src_pri,
  output logic       osc_ready,
  output logic       core_stall
);

  localparam int N_EVENTS = 5;

  logic [N_EVENTS-1:0] ev_vec;
  logic                ev_any;
  logic                crystal;
  logic                hold_osc;
  logic                busy;
  logic                done_osc;
  logic                done_sys;

  assign ev_vec  = {ev_pwrt, ev_osc_en, ev_wake, ev_bor, ev_por};
  assign ev_any  = |ev_vec;
  assign crystal = mode_is_crystal(osc_mode);

  ost_restart_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .sys_clk  (sys_clk),
    .osc_clk  (osc_clk),
    .rst_n    (rst_n),
    .ev_any   (ev_any),
    .hold_osc (hold_osc),
    .busy     (busy)
  );

  ost_cycle_counter #(.LIMIT(COUNT_LIMIT)) u_count (
    .osc_clk (osc_clk),
    .rst_n   (rst_n),
    .hold    (hold_osc),
    .done    (done_osc)
  );

  ost_sync #(.W(1), .STAGES(SYNC_STAGES)) u_done_sync (
    .clk   (sys_clk),
    .rst_n (rst_n),
    .d     (done_osc),
    .q     (done_sys)
  );

  assign osc_ready  = !crystal || (done_sys && !busy);
  assign core_stall = crystal && clk_src_pri && !osc_ready;

  // ready drops on the cycle after any event in a crystal mode
  assert_event_clears_ready_R4: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (ev_any && crystal) |=> (!osc_ready || !mode_is_crystal(osc_mode)));

  // once ready, stays ready until an event or a mode change
  assert_ready_sticky_R7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (osc_ready && !ev_any && $stable(osc_mode)) |=> osc_ready);

  // no stall unless the core runs from this oscillator
  assert_stall_needs_source_R6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    core_stall |-> (clk_src_pri && !osc_ready));

endmodule

// File: tb/osc_startup_timer_tb.sv
`timescale 1ns/100ps
module osc_startup_timer_tb;

  logic       sys_clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] osc_mode = 3'd1;
  logic       ev_por = 1'b0, ev_bor = 1'b0, ev_wake = 1'b0, ev_osc_en = 1'b0, ev_pwrt = 1'b0;
  logic       clk_src_pri = 1'b1;
  logic       osc_ready;
  logic       core_stall;

  int total = 0;
  int bad = 0;
  int osc_edges = 0;
  int base = 0;

  always #2.5 sys_clk = ~sys_clk;
  always #15 osc_clk = ~osc_clk;
  always @(posedge osc_clk) osc_edges++;

  osc_startup_timer u_dut (
    .sys_clk     (sys_clk),
    .osc_clk     (osc_clk),
    .rst_n       (rst_n),
    .osc_mode    (osc_mode),
    .ev_por      (ev_por),
    .ev_bor      (ev_bor),
    .ev_wake     (ev_wake),
    .ev_osc_en   (ev_osc_en),
    .ev_pwrt     (ev_pwrt),
    .clk_src_pri (clk_src_pri),
    .osc_ready   (osc_ready),
    .core_stall  (core_stall)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // one-cycle pulse; base = oscillator edges seen up to the sampling edge
  task automatic fire(input logic [4:0] which);
    @(negedge sys_clk);
    {ev_pwrt, ev_osc_en, ev_wake, ev_bor, ev_por} = which;
    @(posedge sys_clk);
    #1 base = osc_edges;
    @(negedge sys_clk);
    {ev_pwrt, ev_osc_en, ev_wake, ev_bor, ev_por} = '0;
  endtask

  task automatic wait_edges(input int n);
    wait (osc_edges >= base + n);
    #20;
  endtask

  task automatic t_reset;
    #100 rst_n = 1'b1;
    base = osc_edges;
    #1;
    chk("R2", "ready after reset", osc_ready, 1'b0);
    chk("R6", "stall after reset", core_stall, 1'b1);
    wait_edges(1023);
    chk("R2", "ready at edge 1023", osc_ready, 1'b0);
    wait_edges(1024);
    chk("R2", "ready at edge 1024", osc_ready, 1'b1);
    chk("R6", "stall once ready", core_stall, 1'b0);
  endtask

  task automatic t_event(input logic [4:0] which, input string req);
    chk(req, "ready before event", osc_ready, 1'b1);
    fire(which);
    chk("R4", "ready just after event", osc_ready, 1'b0);
    wait_edges(1027);
    chk(req, "ready at edge 1027", osc_ready, 1'b0);
    wait_edges(1028);
    chk(req, "ready at edge 1028", osc_ready, 1'b1);
  endtask

  task automatic t_midcount;
    fire(5'b00001);
    wait_edges(500);
    chk("R5", "mid count ready", osc_ready, 1'b0);
    fire(5'b00010);
    wait_edges(1027);
    chk("R5", "restarted count edge 1027", osc_ready, 1'b0);
    wait_edges(1028);
    chk("R5", "restarted count edge 1028", osc_ready, 1'b1);
  endtask

  task automatic t_stall;
    fire(5'b01000);
    chk("R6", "stall while counting", core_stall, 1'b1);
    clk_src_pri = 1'b0;
    #1;
    chk("R6", "no stall on other source", core_stall, 1'b0);
    chk("R6", "ready still low", osc_ready, 1'b0);
    clk_src_pri = 1'b1;
    #1;
    chk("R6", "stall back on", core_stall, 1'b1);
    wait_edges(1028);
    chk("R6", "stall released", core_stall, 1'b0);
  endtask

  task automatic t_saturate;
    base = osc_edges;
    wait_edges(1100);
    chk("R7", "ready held after 1100 more edges", osc_ready, 1'b1);
    chk("R7", "no stall while held", core_stall, 1'b0);
  endtask

  task automatic t_noncrystal;
    fire(5'b00100);
    osc_mode = 3'd5;
    #1;
    chk("R1", "ready in mode 5 mid count", osc_ready, 1'b1);
    chk("R1", "stall in mode 5", core_stall, 1'b0);
    fire(5'b00001);
    chk("R1", "ready after event in mode 5", osc_ready, 1'b1);
    osc_mode = 3'd3;
    #1;
    chk("R1", "ready in mode 3", osc_ready, 1'b1);
    osc_mode = 3'd0;
    #1;
    chk("R1", "low-power crystal counts", osc_ready, 1'b0);
    wait_edges(1028);
    chk("R1", "low-power crystal done", osc_ready, 1'b1);
  endtask

  task automatic t_simul;
    osc_mode = 3'd2;
    fire(5'b10011);
    chk("R8", "ready after joint events", osc_ready, 1'b0);
    wait_edges(1027);
    chk("R8", "joint events edge 1027", osc_ready, 1'b0);
    wait_edges(1028);
    chk("R8", "joint events edge 1028", osc_ready, 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge sys_clk);
    total++;
    bad++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    for (int i = 0; i < 5; i++) t_event(5'(1 << i), "R3");
    t_midcount();
    t_stall();
    t_saturate();
    t_noncrystal();
    t_simul();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule